// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block gives two independently clocked ports a side channel that bypasses the data FIFO between them. Mailbox 1 carries one word from port A to port B; mailbox 2 carries one word from port B to port A. Each mailbox owns an active-low "mail present" flag that lives in the writer's clock domain. A write raises the mail condition, and the flag blocks any further write into that mailbox until the reader on the other side has taken the word.

Each port has an enable, a write/read direction bit and a mailbox-select bit. When the select bit is high, the access goes to the mailbox. When it is low, the access is steered to the FIFO: a port A write raises `fifo_wr`, and a port B read raises `fifo_rd` and captures `fifo_q` into the port B output register. Set and clear events cross between the clock domains as toggles passed through synchronizer chains. A flag therefore goes low on the writer's own edge, but returns high only a few writer cycles after the reader's edge.

Both resets are synchronous and active high. `rst_a` and `rst_b` must be asserted together for at least `SYNC_STAGES + 2` cycles of the slower clock.

Top module: `mbx_pair`

## Requirements
- R1: After reset, `mbf1_n` and `mbf2_n` are high, and `a_dout` and `b_dout` are zero.
- R2: A port A write with `a_sel` high, made while `mbf1_n` is high, stores `a_din` in mailbox 1. `mbf1_n` is low after that `clk_a` edge.
- R3: A port A mailbox write made while `mbf1_n` is low is ignored. The stored word is unchanged and `mbf1_n` stays low.
- R4: A port B read (`b_wr` = 0) with `b_sel` high loads the delivered mailbox 1 word into `b_dout` on that `clk_b` edge. `mbf1_n` then returns high within 8 `clk_a` cycles.
- R5: A port B read with `b_sel` low raises `fifo_rd` in the same cycle and loads `fifo_q` into `b_dout`. `b_dout` holds whenever port B does not read.
- R6: Mailbox 2 mirrors mailbox 1. A port B write (`b_wr` = 1, `b_sel` = 1) drives `mbf2_n` low and blocks further writes. A port A read (`a_wr` = 0, `a_sel` = 1) returns the word on `a_dout` and releases `mbf2_n`. `a_dout` changes only on such a read.
- R7: A mailbox read while the mailbox holds no undelivered word returns the last delivered word and does not clear the next word written.
- R8: `fifo_wr` is high exactly for a port A write with `a_sel` low. A mailbox write does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Synchronous active-high reset, port A side |
| a_en | input | 1 | Port A access enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_sel | input | 1 | Port A mailbox select |
| a_din | input | DATA_W | Port A write data |
| a_dout | output | DATA_W | Port A read data (mailbox 2) |
| mbf1_n | output | 1 | Mailbox 1 full flag, active low, `clk_a` domain |
| fifo_wr | output | 1 | Port A FIFO write strobe |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Synchronous active-high reset, port B side |
| b_en | input | 1 | Port B access enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_sel | input | 1 | Port B mailbox select |
| b_din | input | DATA_W | Port B write data |
| fifo_q | input | DATA_W | FIFO output register value |
| fifo_rd | output | 1 | Port B FIFO read strobe |
| b_dout | output | DATA_W | Port B read data |
| mbf2_n | output | 1 | Mailbox 2 full flag, active low, `clk_b` domain |

## Verification
The hardest case to reach from the ports is a read of an empty mailbox that takes place before the next word arrives. Such a read must not leave a pending clear that would release the next word early. The stimulus reads a mailbox right after it is released, then writes a new word. It holds that word unread for many writer cycles and checks that the flag stays low. The bench also tries blocked writes while a flag is low, and random values and gaps on two clocks of unrelated period let the crossings land at many phases.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef struct packed {
    logic en;
    logic wr;
    logic sel;
  } port_ctl_t;

  function automatic logic mb_write(port_ctl_t c);
    return c.en & c.wr & c.sel;
  endfunction

  function automatic logic mb_read(port_ctl_t c);
    return c.en & ~c.wr & c.sel;
  endfunction

  function automatic logic fifo_write(port_ctl_t c);
    return c.en & c.wr & ~c.sel;
  endfunction

  function automatic logic fifo_read(port_ctl_t c);
    return c.en & ~c.wr & ~c.sel;
  endfunction
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wdata,
  output logic              wfull_n,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rdata
);
  logic              set_t, set_s, set_seen;
  logic              clr_t, clr_s;
  logic              rd_full;
  logic [DATA_W-1:0] mbox_q, rcopy;

  // Writer domain: a write toggles the set event and stores the word
  always_ff @(posedge wclk) begin
    if (wrst) begin
      set_t  <= 1'b0;
      mbox_q <= '0;
    end else if (wr_req && wfull_n) begin
      set_t  <= ~set_t;
      mbox_q <= wdata;
    end
  end

  mbx_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk(wclk), .rst(wrst), .d(clr_t), .q(clr_s)
  );

  assign wfull_n = (set_t == clr_s);

  // Reader domain: take a copy once the set event arrives, toggle clear on read
  mbx_sync #(.STAGES(SYNC_STAGES)) u_set_sync (
    .clk(rclk), .rst(rrst), .d(set_t), .q(set_s)
  );

  assign rd_full = set_seen ^ clr_t;

  always_ff @(posedge rclk) begin
    if (rrst) begin
      set_seen <= 1'b0;
      clr_t    <= 1'b0;
      rcopy    <= '0;
    end else begin
      if (set_s != set_seen) begin
        set_seen <= set_s;
        rcopy    <= mbox_q;
      end
      if (rd_req && rd_full) clr_t <= ~clr_t;
    end
  end

  assign rdata = rcopy;

  AST_SET_FLAG: assert property (@(posedge wclk) disable iff (wrst)
    (wr_req && wfull_n) |=> !wfull_n); // R2
  AST_BLOCKED_WRITE: assert property (@(posedge wclk) disable iff (wrst)
    (wr_req && !wfull_n) |=> $stable(mbox_q)); // R3
  AST_EMPTY_READ: assert property (@(posedge rclk) disable iff (rrst)
    (rd_req && !rd_full) |=> $stable(clr_t)); // R7
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_a,
  input  logic              rst_a,
  input  logic              a_en,
  input  logic              a_wr,
  input  logic              a_sel,
  input  logic [DATA_W-1:0] a_din,
  output logic [DATA_W-1:0] a_dout,
  output logic              mbf1_n,
  output logic              fifo_wr,
  input  logic              clk_b,
  input  logic              rst_b,
  input  logic              b_en,
  input  logic              b_wr,
  input  logic              b_sel,
  input  logic [DATA_W-1:0] b_din,
  input  logic [DATA_W-1:0] fifo_q,
  output logic              fifo_rd,
  output logic [DATA_W-1:0] b_dout,
  output logic              mbf2_n
);
  port_ctl_t         ctl_a, ctl_b;
  logic [DATA_W-1:0] mb1_rdata, mb2_rdata;

  assign ctl_a   = '{en: a_en, wr: a_wr, sel: a_sel};
  assign ctl_b   = '{en: b_en, wr: b_wr, sel: b_sel};
  assign fifo_wr = fifo_write(ctl_a);
  assign fifo_rd = fifo_read(ctl_b);

  mbx_chan #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mb1 (
    .wclk(clk_a), .wrst(rst_a), .wr_req(mb_write(ctl_a)), .wdata(a_din),
    .wfull_n(mbf1_n),
    .rclk(clk_b), .rrst(rst_b), .rd_req(mb_read(ctl_b)), .rdata(mb1_rdata)
  );

  mbx_chan #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mb2 (
    .wclk(clk_b), .wrst(rst_b), .wr_req(mb_write(ctl_b)), .wdata(b_din),
    .wfull_n(mbf2_n),
    .rclk(clk_a), .rrst(rst_a), .rd_req(mb_read(ctl_a)), .rdata(mb2_rdata)
  );

  always_ff @(posedge clk_b) begin
    if (rst_b)                b_dout <= '0;
    else if (mb_read(ctl_b))  b_dout <= mb1_rdata;
    else if (fifo_read(ctl_b)) b_dout <= fifo_q;
  end

  always_ff @(posedge clk_a) begin
    if (rst_a)               a_dout <= '0;
    else if (mb_read(ctl_a)) a_dout <= mb2_rdata;
  end

  AST_B_DOUT_HOLD: assert property (@(posedge clk_b) disable iff (rst_b)
    !(b_en && !b_wr) |=> $stable(b_dout)); // R5
  AST_A_DOUT_HOLD: assert property (@(posedge clk_a) disable iff (rst_a)
    !(a_en && !a_wr && a_sel) |=> $stable(a_dout)); // R6
  AST_MB_NOT_FIFO: assert property (@(posedge clk_a) disable iff (rst_a)
    (a_en && a_sel) |-> !fifo_wr); // R8
endmodule

// File: tb/mbx_pair_tb.sv
module mbx_pair_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_B_HALF = (CLK_PERIOD * 7) / 10;
  localparam int W = 36;
  localparam int CLR_LIMIT = 8;

  logic clk_a = 0, clk_b = 0, rst_a = 1, rst_b = 1;
  logic a_en = 0, a_wr = 0, a_sel = 0, b_en = 0, b_wr = 0, b_sel = 0;
  logic [W-1:0] a_din = '0, b_din = '0, fifo_q = '0;
  logic [W-1:0] a_dout, b_dout;
  logic mbf1_n, mbf2_n, fifo_wr, fifo_rd;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk_a = ~clk_a;
  always #(CLK_B_HALF) clk_b = ~clk_b;

  mbx_pair #(.DATA_W(W), .SYNC_STAGES(2)) dut_i (
    .clk_a(clk_a), .rst_a(rst_a), .a_en(a_en), .a_wr(a_wr), .a_sel(a_sel),
    .a_din(a_din), .a_dout(a_dout), .mbf1_n(mbf1_n), .fifo_wr(fifo_wr),
    .clk_b(clk_b), .rst_b(rst_b), .b_en(b_en), .b_wr(b_wr), .b_sel(b_sel),
    .b_din(b_din), .fifo_q(fifo_q), .fifo_rd(fifo_rd), .b_dout(b_dout),
    .mbf2_n(mbf2_n)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd_word();
    return {$urandom(), $urandom()} & {W{1'b1}};
  endfunction

  // One port A access; strobe values are sampled while the inputs are driven
  task automatic op_a(input logic wr, input logic sel, input logic [W-1:0] d, output logic fw);
    @(negedge clk_a);
    a_en = 1; a_wr = wr; a_sel = sel; a_din = d;
    #1 fw = fifo_wr;
    @(negedge clk_a);
    a_en = 0; a_wr = 0; a_sel = 0;
  endtask

  task automatic op_b(input logic wr, input logic sel, input logic [W-1:0] d, output logic fr);
    @(negedge clk_b);
    b_en = 1; b_wr = wr; b_sel = sel; b_din = d;
    #1 fr = fifo_rd;
    @(negedge clk_b);
    b_en = 0; b_wr = 0; b_sel = 0;
  endtask

  task automatic wait_a(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_a);
  endtask
  task automatic wait_b(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_b);
  endtask

  task automatic wait_mbf1_high(output bit ok);
    ok = 0;
    for (int i = 0; i < CLR_LIMIT; i++) begin
      if (mbf1_n) begin ok = 1; break; end
      @(negedge clk_a);
    end
    if (mbf1_n) ok = 1;
  endtask
  task automatic wait_mbf2_high(output bit ok);
    ok = 0;
    for (int i = 0; i < CLR_LIMIT; i++) begin
      if (mbf2_n) begin ok = 1; break; end
      @(negedge clk_b);
    end
    if (mbf2_n) ok = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic s;
    bit ok;
    logic [W-1:0] v1, v2, fv;
    void'($urandom(32'd1234));
    wait_b(8);
    @(negedge clk_a); rst_a = 0;
    @(negedge clk_b); rst_b = 0;
    wait_a(2);
    // R1 reset state
    chk(mbf1_n === 1'b1, "R1 mbf1_n", W'(mbf1_n), 1);
    chk(mbf2_n === 1'b1, "R1 mbf2_n", W'(mbf2_n), 1);
    chk(a_dout === '0, "R1 a_dout", a_dout, 0);
    chk(b_dout === '0, "R1 b_dout", b_dout, 0);

    // R2 / R8: mailbox 1 write
    v1 = 36'h1_1111_1111;
    op_a(1, 1, v1, s);
    chk(s === 1'b0, "R8 fifo_wr on mailbox write", W'(s), 0);
    chk(mbf1_n === 1'b0, "R2 mbf1_n after write", W'(mbf1_n), 0);
    // R3: blocked write
    op_a(1, 1, 36'h2_2222_2222, s);
    wait_a(10);
    chk(mbf1_n === 1'b0, "R3 mbf1_n stays low", W'(mbf1_n), 0);
    wait_b(6);
    // R4: read returns first word and releases flag
    op_b(0, 1, '0, s);
    chk(s === 1'b0, "R5 fifo_rd on mailbox read", W'(s), 0);
    chk(b_dout === v1, "R3 R4 b_dout mailbox 1", b_dout, v1);
    wait_mbf1_high(ok);
    chk(ok, "R4 mbf1_n released", W'(mbf1_n), 1);

    // R7: empty read, then new word must stay held
    wait_b(6);
    op_b(0, 1, '0, s);
    chk(b_dout === v1, "R7 empty read returns last", b_dout, v1);
    v2 = 36'h3_3333_3333;
    op_a(1, 1, v2, s);
    wait_a(20);
    chk(mbf1_n === 1'b0, "R7 new word not released early", W'(mbf1_n), 0);
    wait_b(6);
    op_b(0, 1, '0, s);
    chk(b_dout === v2, "R7 new word read", b_dout, v2);
    wait_mbf1_high(ok);
    chk(ok, "R4 mbf1_n released again", W'(mbf1_n), 1);

    // R5 / R8: FIFO steering
    fv = rnd_word();
    fifo_q = fv;
    op_b(0, 0, '0, s);
    chk(s === 1'b1, "R5 fifo_rd", W'(s), 1);
    chk(b_dout === fv, "R5 b_dout from fifo_q", b_dout, fv);
    wait_b(3);
    chk(b_dout === fv, "R5 b_dout holds", b_dout, fv);
    op_a(1, 0, rnd_word(), s);
    chk(s === 1'b1, "R8 fifo_wr", W'(s), 1);
    chk(mbf1_n === 1'b1, "R8 mbf1_n untouched by fifo write", W'(mbf1_n), 1);
    op_b(1, 0, rnd_word(), s);
    chk(mbf2_n === 1'b1, "R6 mbf2_n untouched by non-mailbox write", W'(mbf2_n), 1);

    // R6: mailbox 2 directed
    v1 = 36'h4_4444_4444;
    op_b(1, 1, v1, s);
    chk(mbf2_n === 1'b0, "R6 mbf2_n after write", W'(mbf2_n), 0);
    op_b(1, 1, 36'h5_5555_5555, s);
    op_a(1, 1, 36'h6_6666_6666, s);  // fills mailbox 1; a_dout must not move
    chk(a_dout === '0, "R6 a_dout holds without read", a_dout, 0);
    wait_a(6);
    op_a(0, 1, '0, s);
    chk(a_dout === v1, "R6 a_dout mailbox 2", a_dout, v1);
    wait_mbf2_high(ok);
    chk(ok, "R6 mbf2_n released", W'(mbf2_n), 1);
    wait_b(6);
    op_b(0, 1, '0, s);
    chk(b_dout === 36'h6_6666_6666, "R4 mailbox 1 while mailbox 2 busy", b_dout, 36'h6_6666_6666);
    wait_mbf1_high(ok);

    // Random traffic on both mailboxes
    for (int it = 0; it < 40; it++) begin
      v1 = rnd_word();
      if ($urandom_range(0, 1) == 0) begin
        op_a(1, 1, v1, s);
        chk(mbf1_n === 1'b0, "R2 random flag low", W'(mbf1_n), 0);
        if ($urandom_range(0, 1) == 1) op_a(1, 1, ~v1, s);
        wait_b(5 + $urandom_range(0, 4));
        op_b(0, 1, '0, s);
        chk(b_dout === v1, "R4 random mailbox 1 data", b_dout, v1);
        wait_mbf1_high(ok);
        chk(ok, "R4 random release", W'(mbf1_n), 1);
      end else begin
        op_b(1, 1, v1, s);
        chk(mbf2_n === 1'b0, "R6 random flag low", W'(mbf2_n), 0);
        if ($urandom_range(0, 1) == 1) op_b(1, 1, ~v1, s);
        wait_a(5 + $urandom_range(0, 4));
        op_a(0, 1, '0, s);
        chk(a_dout === v1, "R6 random mailbox 2 data", a_dout, v1);
        wait_mbf2_high(ok);
        chk(ok, "R6 random release", W'(mbf2_n), 1);
      end
      wait_a($urandom_range(0, 5));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule